// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the bus clock. A programmable divider has two ratio laws, picked by a single select bit. One is a power-of-two law driven by a 4-bit exponent. The other is a linear, even-ratio law driven by an 8-bit value. On top of the divider, the block applies a polarity bit and a phase bit so that all four SPI modes are available.

Besides the pin level, the block emits two single-cycle strobes for a neighbouring data shifter. One marks the edge on which the shifter launches the next bit. The other marks the edge on which it captures the incoming bit.

Configuration (law, divider, polarity, phase) is captured from its inputs only while the block is disabled. Enabling the block starts the clock with a full-length first half period. Disabling it parks the pin at the level set by the polarity bit.

Top module: `spi_sck_gen`

## Requirements
- R1: During and right after reset, `sck` is 0 and both strobes are 0. The stored configuration is: law 0, divider 0, polarity 0, phase 0.
- R2: With the stored law bit at 0 (power-of-two law), each half period of `sck` lasts 2^E bus cycles, where E is bits [3:0] of the stored divider. The full ratio is therefore 2^(E+1). Bits [7:4] of the divider have no effect in this law.
- R3: With the stored law bit at 1 (linear law), each half period lasts N+1 bus cycles, where N is the stored 8-bit divider (0..255). The full ratio is therefore 2*(N+1).
- R4: In every cycle after one in which `en` was sampled low, `sck` equals the stored polarity bit and both strobes are 0.
- R5: Once `en` is sampled high after being low, the first `sck` edge appears after exactly one full half period, counted from that first sampled-high edge.
- R6: A configuration write (`cfg_wr` high) sampled while `en` is high changes nothing. The timing and polarity of `sck` continue unchanged.
- R7: With phase 0, `sample_stb` marks leading edges and `shift_stb` marks trailing edges. A leading edge moves `sck` away from its rest level.
- R8: With phase 1, `shift_stb` marks leading edges and `sample_stb` marks trailing edges.
- R9: Each strobe is a single-cycle pulse. A strobe is high exactly in the cycle in which `sck` shows its new level. The two strobes are never high together.
- R10: A configuration write sampled while `en` is low takes effect from the next cycle. In particular, the `sck` rest level follows a polarity change one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Controller enable; clock runs while high |
| cfg_wr | input | 1 | Configuration write strobe, honoured only while `en` is low |
| cfg_lin | input | 1 | Law select: 0 power-of-two, 1 linear |
| cfg_div | input | 8 | Divider value (exponent in its low 4 bits for law 0) |
| cfg_cpol | input | 1 | Clock polarity (rest level of `sck`) |
| cfg_cpha | input | 1 | Clock phase (0: sample on leading edge) |
| sck | output | 1 | Serial clock pin level |
| shift_stb | output | 1 | One-cycle strobe: shifter launches next bit |
| sample_stb | output | 1 | One-cycle strobe: shifter captures input bit |

## Verification
The assertions take for granted that configuration only changes while `en` is low. They also assume that reset holds the strobes low, so every edge they see traces back to a counter that began at zero. The stimulus respects both assumptions in an ordinary way. Every legitimate reconfiguration happens with `en` low. Writes issued while `en` is high exist only to confirm that they are dropped. Each run of the clock begins from a disabled state, so the first half period is always the full length.

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_wr,
  input  logic             cfg_lin,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  output logic             sck,
  output logic             shift_stb,
  output logic             sample_stb
);
  localparam int PW    = 2 ** EXP_W;
  localparam int CNT_W = (PW > DIV_W + 1) ? PW : DIV_W + 1;

  logic             lin_q, cpol_q, cpha_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt, half_m1;
  logic             lvl;
  logic             hit;
  logic             lead_smp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_q  <= 1'b0;
      div_q  <= '0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
    end else if (cfg_wr && !en) begin
      lin_q  <= cfg_lin;
      div_q  <= cfg_div;
      cpol_q <= cfg_cpol;
      cpha_q <= cfg_cpha;
    end
  end

  assign half_m1 = lin_q ? CNT_W'(div_q)
                         : (CNT_W'(1) << div_q[EXP_W-1:0]) - CNT_W'(1);
  assign hit      = en && (cnt == half_m1);
  assign lead_smp = ~lvl ^ cpha_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt        <= '0;
      lvl        <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      cnt        <= hit ? '0 : cnt + CNT_W'(1);
      lvl        <= lvl ^ hit;
      sample_stb <= hit && lead_smp;
      shift_stb  <= hit && !lead_smp;
    end
  end

  assign sck = cpol_q ^ lvl;
endmodule

module spi_sck_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sck,
  input logic             shift_stb,
  input logic             sample_stb,
  input logic             cpol_q,
  input logic             cpha_q,
  input logic             lin_q,
  input logic [DIV_W-1:0] div_q
);
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sck == cpol_q) && !shift_stb && !sample_stb);
  // R6
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable({lin_q, div_q, cpol_q, cpha_q}));
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_stb, sample_stb}));
  // R9
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb || sample_stb) |-> (sck != $past(sck)));
  // R7
  sample_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> ((sck ^ cpol_q) == !cpha_q));
  // R8
  shift_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> ((sck ^ cpol_q) == cpha_q));
endmodule

bind spi_sck_gen spi_sck_gen_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .sck(sck),
  .shift_stb(shift_stb), .sample_stb(sample_stb),
  .cpol_q(cpol_q), .cpha_q(cpha_q), .lin_q(lin_q), .div_q(div_q)
);

// File: tb/spi_sck_gen_tb.sv
module spi_sck_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cfg_wr = 1'b0;
  logic cfg_lin = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic sck, shift_stb, sample_stb;

  always #2 clk = ~clk;

  spi_sck_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .cfg_lin(cfg_lin),
    .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sck(sck), .shift_stb(shift_stb), .sample_stb(sample_stb)
  );

  int n_cmp = 0, n_bad = 0;
  string req = "R1";
  int m_lin = 0, m_div = 0, m_pol = 0, m_pha = 0, since = 0;
  int edges_seen = 0;
  bit done = 0;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      int h, k, e_sck, e_sh, e_sa;
      bit edge_now, leading;
      @(posedge clk);
      if (!rst_n) begin
        m_lin = 0; m_div = 0; m_pol = 0; m_pha = 0; since = 0;
      end else begin
        if (cfg_wr && !en) begin
          m_lin = cfg_lin; m_div = cfg_div; m_pol = cfg_cpol; m_pha = cfg_cpha;
        end
        since = en ? since + 1 : 0;
      end
      h = m_lin ? m_div + 1 : (1 << (m_div % 16));
      k = since / h;
      edge_now = (since > 0) && (since % h == 0);
      leading = k % 2;
      e_sck = m_pol ^ (k % 2);
      e_sa = edge_now && (leading == !m_pha);
      e_sh = edge_now && !(leading == !m_pha);
      #1;
      n_cmp++;
      if (edge_now) edges_seen++;
      if (sck !== e_sck[0] || shift_stb !== e_sh[0] || sample_stb !== e_sa[0]) begin
        n_bad++;
        $display("FAIL %s: got sck=%b sh=%b sa=%b expected sck=%0d sh=%0d sa=%0d",
                 req, sck, shift_stb, sample_stb, e_sck, e_sh, e_sa);
      end
      @(negedge clk);
    end
  endtask

  task automatic cfg(input bit lin, input int dv, input bit pol, input bit pha);
    cfg_lin = lin; cfg_div = 8'(dv); cfg_cpol = pol; cfg_cpha = pha;
    cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    req = "R1"; cyc(3);
    rst_n = 1'b1; cyc(2);
    // R2 power-of-two law, several exponents, upper bits ignored
    req = "R2"; cfg(0, 0, 0, 0); en = 1; cyc(12); en = 0; cyc(2);
    cfg(0, 2, 0, 0); en = 1; cyc(40); en = 0; cyc(2);
    cfg(0, 8'hF1, 0, 0); en = 1; cyc(20); en = 0; cyc(2);
    cfg(0, 9, 0, 0); en = 1; cyc(2200); en = 0; cyc(2);
    // R3 linear law
    req = "R3"; cfg(1, 0, 0, 0); en = 1; cyc(10); en = 0; cyc(2);
    cfg(1, 4, 0, 0); en = 1; cyc(40); en = 0; cyc(2);
    cfg(1, 255, 0, 0); en = 1; cyc(1100); en = 0; cyc(2);
    // R7 R8 all four polarity/phase combinations
    req = "R7"; cfg(1, 2, 0, 0); en = 1; cyc(30); en = 0; cyc(2);
    cfg(1, 2, 1, 0); en = 1; cyc(30); en = 0; cyc(2);
    req = "R8"; cfg(1, 2, 0, 1); en = 1; cyc(30); en = 0; cyc(2);
    cfg(1, 2, 1, 1); en = 1; cyc(30); en = 0; cyc(2);
    // R10 polarity follows a write while disabled
    req = "R10"; cfg(0, 1, 1, 0); cyc(2); cfg(0, 1, 0, 0); cyc(2);
    // R4 park level after disable mid-period, polarity 1
    req = "R4"; cfg(1, 5, 1, 0); en = 1; cyc(9); en = 0; cyc(6);
    // R5 re-enable gives full first half period
    req = "R5"; en = 1; cyc(3); en = 0; cyc(1); en = 1; cyc(30); en = 0; cyc(2);
    // R6 writes while enabled are dropped
    req = "R6"; cfg(1, 3, 0, 1); en = 1; cyc(5);
    cfg(0, 0, 1, 0); cyc(3); cfg(1, 7, 1, 1); cyc(40); en = 0; cyc(3);
    // R9 strobe shape is covered on every compared cycle; check that edges occurred
    req = "R9"; n_cmp++;
    if (edges_seen < 50) begin
      n_bad++;
      $display("FAIL R9: got %0d edges expected at least 50", edges_seen);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule